// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command interpreter of a byte-wide flash memory model. Each bus write arrives as a one-cycle strobe carrying an address and a data byte. The block follows a fixed unlock prefix and then one of several command paths. It uses them to run a byte program, a whole-array erase, a permanent lock of the boot sector, or entry to and exit from a read-only identification window. It also enforces the array rules. The erased value is 0xFF, a program can only clear bits, and a locked boot sector refuses both program and erase.

The storage is a small register array. It has two halves: one half holds the boot sector and the other holds the rest of the address space. Within each half, the low address bits pick the row. Reads are combinational from the read address. Busy timing and status polling live in a neighbouring block. That block receives a one-cycle pulse when a program or an erase is accepted, and it returns a busy level that freezes the decoder.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rst_n` is released, every location reads 0xFF, the identification window is closed and the boot lock is clear.
- R2: A command starts only with 0xAA written to address 0x5555 followed by 0x55 written to 0x2AAA. Only address bits 14..0 of these writes are compared, and the higher bits are ignored.
- R3: After the prefix, 0xA0 at 0x5555 arms a program. The next write stores (old value AND written data) at its address, and `prog_pulse` is high in the single cycle after that write.
- R4: After the prefix, the steps 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA and then 0x10 at 0x5555 set every unlocked location to 0xFF. `erase_pulse` is high in the single cycle after the last write.
- R5: The same six-step path ending in 0x40 at 0x5555 sets the boot lock. Only `rst_n` clears the lock.
- R6: While the lock is set, a program into the boot sector changes nothing and gives no `prog_pulse`, and an erase leaves the boot sector intact. Locations outside the sector are still programmed and erased.
- R7: With `TOP_BOOT`=0 the boot sector is every address whose bits [ADDR_W-1:BOOT_AW] are all zero (0x00000..0x03FFF by default). With `TOP_BOOT`=1 it is every address whose bits in that range are all ones (0x7C000..0x7FFFF).
- R8: After the prefix, 0x90 at 0x5555 opens the identification window. In the window, `rd_addr[1:0]` selects the read value: 0 reads 0x1F; 1 reads 0x13 (bottom boot) or 0x12 (top boot); 2 reads the lock in bit 0 with the other bits zero; 3 reads 0x00.
- R9: The window closes on the prefix followed by 0xF0 at 0x5555, or on a single write of 0xF0 to any address while no program is armed. After it closes, reads return the array again.
- R10: A write that does not match the address and data of the current step returns the decoder to idle and has no other effect. The write that follows must start a new prefix.
- R11: A write made while `busy_in` is high is ignored: the step, the lock, the window and the array all keep their values.
- R12: Two locations map to the same storage row when they lie in the same region (boot or main) and share their low `ROW_AW` address bits. Locations in different regions never share a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | One-cycle strobe of a bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy_in | input | 1 | Operation-in-progress level from the status block |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte, or identification byte while the window is open |
| prog_pulse | output | 1 | One-cycle pulse when a program is accepted |
| erase_pulse | output | 1 | One-cycle pulse when an erase is accepted |

## Verification
The assertions assume that every bus write is a single-cycle `wr_en` strobe. They also assume that `busy_in` holds steady across the cycle in which a write is sampled, so that each step change can be traced to exactly one accepted write. The stimulus drives all inputs on falling clock edges and raises `wr_en` for one cycle per write, with at least one idle cycle between writes. It changes `busy_in` only when no write is in flight. The stimulus avoids aliasing between main-region addresses except where the shared-row rule itself is under test.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 19,
  parameter int BOOT_AW  = 14,
  parameter int ROW_AW   = 5,
  parameter int TOP_BOOT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              prog_pulse,
  output logic              erase_pulse
);
  localparam int ROWS     = 2 ** (ROW_AW + 1);
  localparam int HALF     = ROWS / 2;
  localparam int REGION_W = ADDR_W - BOOT_AW;
  localparam logic [7:0] MFR_CODE = 8'h1F;
  localparam logic [7:0] DEV_CODE = (TOP_BOOT != 0) ? 8'h12 : 8'h13;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_UNL1 = 3'd1, S_UNL2 = 3'd2, S_PROG = 3'd3,
    S_EXT1 = 3'd4, S_EXT2 = 3'd5, S_EXT3 = 3'd6
  } step_e;

  step_e      step_q, step_d;
  logic       lock_q, lock_d;
  logic       id_q, id_d;
  logic       do_prog, do_erase;
  logic [7:0] mem_q [ROWS];

  function automatic logic boot_hit(input logic [ADDR_W-1:0] a);
    logic [REGION_W-1:0] hi;
    hi = a[ADDR_W-1:BOOT_AW];
    return (TOP_BOOT != 0) ? (&hi) : ~(|hi);
  endfunction

  function automatic logic [ROW_AW:0] row_of(input logic [ADDR_W-1:0] a);
    return {boot_hit(a), a[ROW_AW-1:0]};
  endfunction

  logic take, at_5555, at_2aaa, wr_boot;
  assign take    = wr_en && !busy_in;
  assign at_5555 = (wr_addr[14:0] == 15'h5555);
  assign at_2aaa = (wr_addr[14:0] == 15'h2AAA);
  assign wr_boot = boot_hit(wr_addr);

  always_comb begin
    step_d   = step_q;
    lock_d   = lock_q;
    id_d     = id_q;
    do_prog  = 1'b0;
    do_erase = 1'b0;
    if (take) begin
      if (id_q && wr_data == 8'hF0 && step_q != S_PROG) begin
        id_d   = 1'b0;
        step_d = S_IDLE;
      end else begin
        step_d = S_IDLE;
        unique case (step_q)
          S_IDLE: if (at_5555 && wr_data == 8'hAA) step_d = S_UNL1;
          S_UNL1: if (at_2aaa && wr_data == 8'h55) step_d = S_UNL2;
          S_UNL2: if (at_5555) begin
            unique case (wr_data)
              8'hA0:   step_d = S_PROG;
              8'h80:   step_d = S_EXT1;
              8'h90:   id_d = 1'b1;
              default: ;
            endcase
          end
          S_PROG: do_prog = !(wr_boot && lock_q);
          S_EXT1: if (at_5555 && wr_data == 8'hAA) step_d = S_EXT2;
          S_EXT2: if (at_2aaa && wr_data == 8'h55) step_d = S_EXT3;
          S_EXT3: if (at_5555) begin
            if (wr_data == 8'h10) do_erase = 1'b1;
            if (wr_data == 8'h40) lock_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= S_IDLE;
      lock_q      <= 1'b0;
      id_q        <= 1'b0;
      prog_pulse  <= 1'b0;
      erase_pulse <= 1'b0;
    end else begin
      step_q      <= step_d;
      lock_q      <= lock_d;
      id_q        <= id_d;
      prog_pulse  <= do_prog;
      erase_pulse <= do_erase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= 8'hFF;
    end else if (do_erase) begin
      for (int r = 0; r < ROWS; r++)
        if (r < HALF || !lock_q) mem_q[r] <= 8'hFF;
    end else if (do_prog) begin
      mem_q[row_of(wr_addr)] <= mem_q[row_of(wr_addr)] & wr_data;
    end
  end

  logic [7:0] id_byte;
  always_comb begin
    unique case (rd_addr[1:0])
      2'd0:    id_byte = MFR_CODE;
      2'd1:    id_byte = DEV_CODE;
      2'd2:    id_byte = {7'd0, lock_q};
      default: id_byte = 8'h00;
    endcase
  end

  assign rd_data = id_q ? id_byte : mem_q[row_of(rd_addr)];

  logic unused_rd_bits;
  assign unused_rd_bits = ^rd_addr[BOOT_AW-1:ROW_AW];
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [14:0] wr_addr_lo,
  input logic [7:0]  wr_data,
  input logic        busy_in,
  input logic [2:0]  step,
  input logic        lock,
  input logic        id_mode,
  input logic        prog_pulse,
  input logic        erase_pulse
);
  localparam logic [2:0] ST_UNL2 = 3'd2;
  localparam logic [2:0] ST_PROG = 3'd3;
  localparam logic [2:0] ST_EXT3 = 3'd6;

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  // R5
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(wr_en) && !$past(busy_in) && $past(step) == ST_EXT3
                    && $past(wr_data) == 8'h40 && $past(wr_addr_lo) == 15'h5555);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy_in) |=> $stable(step) && $stable(lock) && $stable(id_mode)
                           && !prog_pulse && !erase_pulse);

  // R3
  prog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> $past(wr_en) && !$past(busy_in) && $past(step) == ST_PROG);

  // R4
  erase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> $past(step) == ST_EXT3 && $past(wr_data) == 8'h10
                    && $past(wr_addr_lo) == 15'h5555);

  // R10
  quiet_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> step == $past(step));

  // R8
  id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(step) == ST_UNL2 && $past(wr_data) == 8'h90);

  // R9
  id_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en) && $past(wr_data) == 8'hF0);

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prog_pulse, erase_pulse}) <= 1);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr_lo(wr_addr[14:0]),
  .wr_data(wr_data), .busy_in(busy_in), .step(step_q), .lock(lock_q),
  .id_mode(id_q), .prog_pulse(prog_pulse), .erase_pulse(erase_pulse)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy_in = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  rd_data, rd_data_t;
  logic        prog_pulse, erase_pulse, prog_pulse_t, erase_pulse_t;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_in(busy_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .prog_pulse(prog_pulse), .erase_pulse(erase_pulse));

  flash_cmd_decoder #(.TOP_BOOT(1)) u_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_in(busy_in), .rd_addr(rd_addr), .rd_data(rd_data_t),
    .prog_pulse(prog_pulse_t), .erase_pulse(erase_pulse_t));

  // {op[2], addr[19], data[8], expected[8], req[4]}; op 0 = write (expected[1:0] = {erase,prog}), op 1 = read
  localparam int NV = 122;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {2'd1,19'h00100,8'h00,8'hFF,4'd1},   // 0   R1
    {2'd1,19'h7FFFF,8'h00,8'hFF,4'd1},   // 1
    {2'd0,19'h05555,8'hAA,8'h00,4'd3},   // 2   R3 program
    {2'd0,19'h02AAA,8'h55,8'h00,4'd3},
    {2'd0,19'h05555,8'hA0,8'h00,4'd3},
    {2'd0,19'h04010,8'h3C,8'h01,4'd3},
    {2'd1,19'h04010,8'h00,8'h3C,4'd3},   // 6
    {2'd0,19'h05555,8'hAA,8'h00,4'd3},
    {2'd0,19'h02AAA,8'h55,8'h00,4'd3},
    {2'd0,19'h05555,8'hA0,8'h00,4'd3},
    {2'd0,19'h04010,8'hF0,8'h01,4'd3},   // 10
    {2'd1,19'h04010,8'h00,8'h30,4'd3},   // 11  AND rule
    {2'd0,19'h7D555,8'hAA,8'h00,4'd2},   // 12  R2 upper bits ignored
    {2'd0,19'h12AAA,8'h55,8'h00,4'd2},
    {2'd0,19'h35555,8'hA0,8'h00,4'd2},
    {2'd0,19'h04020,8'h0F,8'h01,4'd2},
    {2'd1,19'h04020,8'h00,8'h0F,4'd2},   // 16
    {2'd0,19'h01555,8'hAA,8'h00,4'd2},   // 17  R2 bit 14 compared
    {2'd0,19'h02AAA,8'h55,8'h00,4'd2},
    {2'd0,19'h05555,8'hA0,8'h00,4'd2},
    {2'd0,19'h04038,8'h00,8'h00,4'd2},   // 20
    {2'd1,19'h04038,8'h00,8'hFF,4'd2},   // 21
    {2'd0,19'h05555,8'hAA,8'h00,4'd10},  // 22  R10 wrong data
    {2'd0,19'h02AAA,8'h56,8'h00,4'd10},
    {2'd0,19'h05555,8'hA0,8'h00,4'd10},
    {2'd0,19'h04038,8'h00,8'h00,4'd10},  // 25
    {2'd1,19'h04038,8'h00,8'hFF,4'd10},  // 26
    {2'd0,19'h05555,8'hAA,8'h00,4'd10},  // 27  R10 repeated first step
    {2'd0,19'h05555,8'hAA,8'h00,4'd10},
    {2'd0,19'h02AAA,8'h55,8'h00,4'd10},
    {2'd0,19'h05555,8'hA0,8'h00,4'd10},  // 30
    {2'd0,19'h04038,8'h00,8'h00,4'd10},
    {2'd1,19'h04038,8'h00,8'hFF,4'd10},  // 32
    {2'd0,19'h05555,8'hAA,8'h00,4'd8},   // 33  R8 identification
    {2'd0,19'h02AAA,8'h55,8'h00,4'd8},
    {2'd0,19'h05555,8'h90,8'h00,4'd8},   // 35
    {2'd1,19'h00000,8'h00,8'h1F,4'd8},
    {2'd1,19'h00001,8'h00,8'h13,4'd8},
    {2'd1,19'h00002,8'h00,8'h00,4'd8},
    {2'd1,19'h00003,8'h00,8'h00,4'd8},
    {2'd0,19'h12345,8'hF0,8'h00,4'd9},   // 40  R9 single-write exit
    {2'd1,19'h04010,8'h00,8'h30,4'd9},
    {2'd1,19'h05010,8'h00,8'h30,4'd12},  // 42  R12 alias
    {2'd0,19'h05555,8'hAA,8'h00,4'd7},   // 43  R7 boot edge unlocked
    {2'd0,19'h02AAA,8'h55,8'h00,4'd7},
    {2'd0,19'h05555,8'hA0,8'h00,4'd7},   // 45
    {2'd0,19'h03FFF,8'h5A,8'h01,4'd7},
    {2'd1,19'h03FFF,8'h00,8'h5A,4'd7},
    {2'd1,19'h0401F,8'h00,8'hFF,4'd12},  // 48  R12 regions separate
    {2'd0,19'h05555,8'hAA,8'h00,4'd4},   // 49  R4 erase
    {2'd0,19'h02AAA,8'h55,8'h00,4'd4},   // 50
    {2'd0,19'h05555,8'h80,8'h00,4'd4},
    {2'd0,19'h05555,8'hAA,8'h00,4'd4},
    {2'd0,19'h02AAA,8'h55,8'h00,4'd4},
    {2'd0,19'h05555,8'h10,8'h02,4'd4},
    {2'd1,19'h03FFF,8'h00,8'hFF,4'd4},   // 55
    {2'd1,19'h04010,8'h00,8'hFF,4'd4},
    {2'd1,19'h04020,8'h00,8'hFF,4'd4},
    {2'd0,19'h05555,8'hAA,8'h00,4'd3},   // 58
    {2'd0,19'h02AAA,8'h55,8'h00,4'd3},
    {2'd0,19'h05555,8'hA0,8'h00,4'd3},   // 60
    {2'd0,19'h00005,8'h81,8'h01,4'd3},
    {2'd1,19'h00005,8'h00,8'h81,4'd3},
    {2'd0,19'h05555,8'hAA,8'h00,4'd3},   // 63
    {2'd0,19'h02AAA,8'h55,8'h00,4'd3},
    {2'd0,19'h05555,8'hA0,8'h00,4'd3},   // 65
    {2'd0,19'h04001,8'h7E,8'h01,4'd3},
    {2'd1,19'h04001,8'h00,8'h7E,4'd3},
    {2'd0,19'h05555,8'hAA,8'h00,4'd5},   // 68  R5 lock
    {2'd0,19'h02AAA,8'h55,8'h00,4'd5},
    {2'd0,19'h05555,8'h80,8'h00,4'd5},   // 70
    {2'd0,19'h05555,8'hAA,8'h00,4'd5},
    {2'd0,19'h02AAA,8'h55,8'h00,4'd5},
    {2'd0,19'h05555,8'h40,8'h00,4'd5},
    {2'd0,19'h05555,8'hAA,8'h00,4'd5},   // 74
    {2'd0,19'h02AAA,8'h55,8'h00,4'd5},   // 75
    {2'd0,19'h05555,8'h90,8'h00,4'd5},
    {2'd1,19'h00002,8'h00,8'h01,4'd5},
    {2'd0,19'h05555,8'hAA,8'h00,4'd9},   // 78  R9 three-write exit
    {2'd0,19'h02AAA,8'h55,8'h00,4'd9},
    {2'd0,19'h05555,8'hF0,8'h00,4'd9},   // 80
    {2'd1,19'h00005,8'h00,8'h81,4'd9},
    {2'd0,19'h05555,8'hAA,8'h00,4'd6},   // 82  R6 locked boot program
    {2'd0,19'h02AAA,8'h55,8'h00,4'd6},
    {2'd0,19'h05555,8'hA0,8'h00,4'd6},
    {2'd0,19'h00005,8'h00,8'h00,4'd6},   // 85
    {2'd1,19'h00005,8'h00,8'h81,4'd6},
    {2'd0,19'h05555,8'hAA,8'h00,4'd6},   // 87
    {2'd0,19'h02AAA,8'h55,8'h00,4'd6},
    {2'd0,19'h05555,8'hA0,8'h00,4'd6},
    {2'd0,19'h04001,8'h0F,8'h01,4'd6},   // 90
    {2'd1,19'h04001,8'h00,8'h0E,4'd6},
    {2'd0,19'h05555,8'hAA,8'h00,4'd7},   // 92  R7 last boot address
    {2'd0,19'h02AAA,8'h55,8'h00,4'd7},
    {2'd0,19'h05555,8'hA0,8'h00,4'd7},
    {2'd0,19'h03FFF,8'h00,8'h00,4'd7},   // 95
    {2'd1,19'h03FFF,8'h00,8'hFF,4'd7},
    {2'd0,19'h05555,8'hAA,8'h00,4'd7},   // 97  R7 first main address
    {2'd0,19'h02AAA,8'h55,8'h00,4'd7},
    {2'd0,19'h05555,8'hA0,8'h00,4'd7},
    {2'd0,19'h04000,8'h11,8'h01,4'd7},   // 100
    {2'd1,19'h04000,8'h00,8'h11,4'd7},
    {2'd0,19'h05555,8'hAA,8'h00,4'd6},   // 102 R6 locked erase
    {2'd0,19'h02AAA,8'h55,8'h00,4'd6},
    {2'd0,19'h05555,8'h80,8'h00,4'd6},
    {2'd0,19'h05555,8'hAA,8'h00,4'd6},   // 105
    {2'd0,19'h02AAA,8'h55,8'h00,4'd6},
    {2'd0,19'h05555,8'h10,8'h02,4'd6},
    {2'd1,19'h00005,8'h00,8'h81,4'd6},
    {2'd1,19'h04001,8'h00,8'hFF,4'd4},
    {2'd0,19'h05555,8'hAA,8'h00,4'd3},   // 110
    {2'd0,19'h02AAA,8'h55,8'h00,4'd3},
    {2'd0,19'h05555,8'hA0,8'h00,4'd3},
    {2'd0,19'h04002,8'h44,8'h01,4'd3},
    {2'd1,19'h04002,8'h00,8'h44,4'd3},
    {2'd0,19'h05555,8'hAA,8'h00,4'd10},  // 115 R10 wrong final code
    {2'd0,19'h02AAA,8'h55,8'h00,4'd10},
    {2'd0,19'h05555,8'h80,8'h00,4'd10},
    {2'd0,19'h05555,8'hAA,8'h00,4'd10},
    {2'd0,19'h02AAA,8'h55,8'h00,4'd10},
    {2'd0,19'h05555,8'h20,8'h00,4'd10},  // 120
    {2'd1,19'h04002,8'h00,8'h44,4'd10}   // 121
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] e, input int req);
    @(negedge clk);
    rd_addr = a;
    #1 check(req, rd_data, e);
  endtask

  task automatic rd_top(input logic [18:0] a, input logic [7:0] e, input int req);
    @(negedge clk);
    rd_addr = a;
    #1 check(req, rd_data_t, e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state: no pulses
    @(negedge clk);
    check(1, {6'd0, erase_pulse, prog_pulse}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [18:0] a; logic [7:0] d, e; logic [3:0] r;
      {op, a, d, e, r} = VEC[i];
      if (op == 2'd0) begin
        wr(a, d);
        check(int'(r), {6'd0, erase_pulse, prog_pulse}, e);
      end else begin
        rd(a, e, int'(r));
      end
    end

    // R11 writes ignored while busy
    busy_in = 1'b1;
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h04003, 8'h33);
    check(11, {6'd0, erase_pulse, prog_pulse}, 8'h00);
    busy_in = 1'b0;
    rd(19'h04003, 8'hFF, 11);
    // R11 step kept across an ignored mismatching write
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    busy_in = 1'b1;
    wr(19'h00000, 8'h00);
    busy_in = 1'b0;
    wr(19'h05555, 8'hA0); wr(19'h04003, 8'h33);
    check(11, {6'd0, erase_pulse, prog_pulse}, 8'h01);
    rd(19'h04003, 8'h33, 11);

    // R1 reset closes the window and erases the array; R5 lock cleared by reset
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
    rd(19'h00002, 8'h01, 5);
    do_reset();
    rd(19'h00000, 8'hFF, 1);
    rd(19'h04003, 8'hFF, 1);
    rd(19'h00005, 8'hFF, 1);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
    rd(19'h00002, 8'h00, 5);
    // R8 top-boot device code
    rd_top(19'h00001, 8'h12, 8);
    rd_top(19'h00000, 8'h1F, 8);
    wr(19'h00000, 8'hF0);

    // R7 top-boot sector protected once locked, main below it still writable
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h40);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h7C010, 8'h00);
    check(7, {7'd0, prog_pulse_t}, 8'h00);
    rd_top(19'h7C010, 8'hFF, 7);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h7BFFF, 8'h55);
    check(7, {7'd0, prog_pulse_t}, 8'h01);
    rd_top(19'h7BFFF, 8'h55, 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule